// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block settles, for one instruction word at a time, whether a short conditional jump is taken. It also works out the program counter and code segment for the next fetch. Each cycle the caller presents a 16-bit instruction word, the four condition flags (carry C, sign S, zero Z, negative N), the current 16-bit program counter and the 6-bit code segment, and marks them with a valid strobe. One clock later the block returns a registered result. The result says whether the word was a jump, whether it is taken, and which segment and PC come next.

A word counts as a jump when bits 11-9 are all zero and the top nibble is anything but 0xF. The top nibble picks the condition. Bits 8-6 give the direction, and bits 5-0 give an unsigned distance of 0 to 63 words. The distance is measured from the word that follows the jump. A jump that is not taken, and any word that is not a jump, simply advances to the next word. The segment and PC are treated as one 22-bit linear address, so a carry out of the PC or a borrow below zero changes the segment, modulo 64.

Top module: `relbr_unit`

## Requirements
- R1: While reset is asserted and in the cycle after it, outValid, isJump and taken are 0, and nextPc and nextSeg are 0.
- R2: isJump is 1 exactly when instruction bits 11-9 equal 0 and bits 15-12 differ from 0xF. Words that are not jumps are never taken.
- R3: For a jump, bits 15-12 select the condition: 0 C=0; 1 C=1; 2 S=0; 3 S=1; 4 Z=0; 5 Z=1; 6 N=0; 7 N=1; 8 Z=1 or C=0; 9 Z=0 and C=1; A Z=1 or S=1; B Z=0 and S=0; C N equals S; D N differs from S; E always.
- R4: A taken jump with bits 8-6 equal to 0 yields {nextSeg,nextPc} = {curSeg,curPc} + 1 + bits 5-0.
- R5: A taken jump with bits 8-6 equal to 1 yields {nextSeg,nextPc} = {curSeg,curPc} + 1 - bits 5-0.
- R6: A jump whose condition is false, or a word that is not a jump, yields {nextSeg,nextPc} = {curSeg,curPc} + 1.
- R7: A jump with bits 8-6 in the range 2 to 7 is never taken and advances as in R6, whatever its condition.
- R8: A PC that passes 0xFFFF while advancing or jumping forward increments the segment, and segment 63 rolls to 0.
- R9: A backward jump that passes below 0x0000 decrements the segment, and segment 0 rolls to 63.
- R10: The result for inputs sampled while inValid is 1 appears on the outputs one clock later, with outValid 1. A cycle with inValid 0 gives outValid 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Inputs in this cycle are to be resolved |
| instrWord | input | 16 | Instruction word under test |
| flagC | input | 1 | Carry flag |
| flagS | input | 1 | Sign flag |
| flagZ | input | 1 | Zero flag |
| flagN | input | 1 | Negative flag |
| curPc | input | 16 | Address of the instruction word |
| curSeg | input | 6 | Current code segment |
| outValid | output | 1 | Registered result is valid |
| isJump | output | 1 | Word was a relative jump |
| taken | output | 1 | Jump is taken |
| nextPc | output | 16 | Program counter of the next fetch |
| nextSeg | output | 6 | Code segment of the next fetch |

## Verification
The properties assume that the reset is asserted low at the start of the run. They also assume that inValid and every operand input carry a defined 0 or 1 at each rising edge, because they compare outputs with $past of the inputs. The stimulus is applied at the falling edge and is never left unknown: idle cycles drive zeros, not X. Segment and PC values are picked near both ends of the address range so that the carry and borrow paths of the segment are reached from both sides.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

  // Strobes passed from the decode/condition control to the address datapath.
  typedef struct packed {
    logic isJump;    // word is a relative jump
    logic condTrue;  // selected condition holds
    logic dirOk;     // direction field is forward or backward
    logic goBack;    // direction field requests a backward jump
  } brStrobes_t;

  // Evaluates one condition code against the flag set.
  function automatic logic condOf(input logic [3:0] code,
                                  input logic c, input logic s,
                                  input logic z, input logic n);
    logic res;
    case (code)
      4'h0:    res = !c;
      4'h1:    res = c;
      4'h2:    res = !s;
      4'h3:    res = s;
      4'h4:    res = !z;
      4'h5:    res = z;
      4'h6:    res = !n;
      4'h7:    res = n;
      4'h8:    res = z || !c;
      4'h9:    res = !z && c;
      4'hA:    res = z || s;
      4'hB:    res = !z && !s;
      4'hC:    res = (n == s);
      4'hD:    res = (n != s);
      4'hE:    res = 1'b1;
      default: res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/relbr_ctrl.sv
module relbr_ctrl
  import relbr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DISP_W = 6
) (
  input  logic [WORD_W-1:0] instrWord,
  input  logic              flagC,
  input  logic              flagS,
  input  logic              flagZ,
  input  logic              flagN,
  output brStrobes_t        strobes,
  output logic [DISP_W-1:0] dispField
);
  // Field layout: [15:12] condition, [11:9] operand A, [8:6] direction, [5:0] distance.
  localparam int COND_HI = WORD_W - 1;
  localparam int COND_LO = WORD_W - 4;
  localparam int OPA_HI  = COND_LO - 1;
  localparam int OPA_LO  = COND_LO - 3;
  localparam int DIR_HI  = OPA_LO - 1;
  localparam int DIR_LO  = OPA_LO - 3;
  localparam int N_COND  = 16;

  logic [3:0]        condCode;
  logic [2:0]        opA;
  logic [2:0]        dirField;
  logic [N_COND-1:0] condVec;

  assign condCode  = instrWord[COND_HI:COND_LO];
  assign opA       = instrWord[OPA_HI:OPA_LO];
  assign dirField  = instrWord[DIR_HI:DIR_LO];
  assign dispField = instrWord[DISP_W-1:0];

  // One evaluator per condition code; the code then selects one of them.
  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    assign condVec[g] = condOf(4'(g), flagC, flagS, flagZ, flagN);
  end

  always_comb begin
    strobes          = '0;
    strobes.isJump   = (opA == 3'd0) && (condCode != 4'hF);
    strobes.condTrue = condVec[condCode];
    strobes.dirOk    = (dirField == 3'd0) || (dirField == 3'd1);
    strobes.goBack   = (dirField == 3'd1);
  end

endmodule

// File: rtl/relbr_path.sv
module relbr_path
  import relbr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int SEG_W  = 6,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  brStrobes_t        strobes,
  input  logic [DISP_W-1:0] dispField,
  input  logic [PC_W-1:0]   curPc,
  input  logic [SEG_W-1:0]  curSeg,
  output logic              outValid,
  output logic              isJump,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic [SEG_W-1:0]  nextSeg
);
  localparam int LIN_W = PC_W + SEG_W;

  logic [LIN_W-1:0] seqAddr;
  logic [LIN_W-1:0] distExt;
  logic [LIN_W-1:0] fwdAddr;
  logic [LIN_W-1:0] bwdAddr;
  logic [LIN_W-1:0] selAddr;
  logic             takeNow;

  assign seqAddr = {curSeg, curPc} + LIN_W'(1);
  assign distExt = {{(LIN_W-DISP_W){1'b0}}, dispField};
  assign fwdAddr = seqAddr + distExt;
  assign bwdAddr = seqAddr - distExt;
  assign takeNow = strobes.isJump && strobes.condTrue && strobes.dirOk;

  always_comb begin
    if (!takeNow)            selAddr = seqAddr;
    else if (strobes.goBack) selAddr = bwdAddr;
    else                     selAddr = fwdAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      isJump   <= 1'b0;
      taken    <= 1'b0;
      nextPc   <= '0;
      nextSeg  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        isJump  <= strobes.isJump;
        taken   <= takeNow;
        nextPc  <= selAddr[PC_W-1:0];
        nextSeg <= selAddr[LIN_W-1:PC_W];
      end
    end
  end

endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
  import relbr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int SEG_W  = 6,
  parameter int DISP_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              flagC,
  input  logic              flagS,
  input  logic              flagZ,
  input  logic              flagN,
  input  logic [PC_W-1:0]   curPc,
  input  logic [SEG_W-1:0]  curSeg,
  output logic              outValid,
  output logic              isJump,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic [SEG_W-1:0]  nextSeg
);
  brStrobes_t        strobes;
  logic [DISP_W-1:0] dispField;

  relbr_ctrl #(.WORD_W(WORD_W), .DISP_W(DISP_W)) u_ctrl (
    .instrWord(instrWord),
    .flagC(flagC),
    .flagS(flagS),
    .flagZ(flagZ),
    .flagN(flagN),
    .strobes(strobes),
    .dispField(dispField)
  );

  relbr_path #(.PC_W(PC_W), .SEG_W(SEG_W), .DISP_W(DISP_W)) u_path (
    .clk(clk),
    .rstN(rstN),
    .inValid(inValid),
    .strobes(strobes),
    .dispField(dispField),
    .curPc(curPc),
    .curSeg(curSeg),
    .outValid(outValid),
    .isJump(isJump),
    .taken(taken),
    .nextPc(nextPc),
    .nextSeg(nextSeg)
  );

endmodule

// File: rtl/relbr_unit_chk.sv
module relbr_unit_chk #(
  parameter int PC_W   = 16,
  parameter int SEG_W  = 6,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [WORD_W-1:0] instrWord,
  input logic              flagC,
  input logic              flagS,
  input logic              flagZ,
  input logic              flagN,
  input logic [PC_W-1:0]   curPc,
  input logic [SEG_W-1:0]  curSeg,
  input logic              outValid,
  input logic              isJump,
  input logic              taken,
  input logic [PC_W-1:0]   nextPc,
  input logic [SEG_W-1:0]  nextSeg
);
  localparam int LIN_W = PC_W + SEG_W;

  // R1: reset clears the result.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && !isJump && !taken && nextPc == '0 && nextSeg == '0));

  // R10: one-cycle latency of the valid strobe.
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R2: non-zero operand A is never a jump nor taken.
  p_not_jump_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[11:9] != 3'd0) |=> (!isJump && !taken));

  // R6: a non-jump word advances by one linear word.
  p_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[11:9] != 3'd0) |=>
      ({nextSeg, nextPc} == LIN_W'($past({curSeg, curPc}) + LIN_W'(1))));

  // R7: illegal direction is never taken.
  p_bad_dir_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[8:6] > 3'd1) |=> !taken);

  // R3: code E with a legal direction is always taken.
  p_always_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[15:12] == 4'hE && instrWord[11:9] == 3'd0 &&
     instrWord[8:7] == 2'b00) |=> taken);

  // R2: a taken result is always a jump.
  p_taken_is_jump_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && taken) |-> isJump);

endmodule

bind relbr_unit relbr_unit_chk #(.PC_W(PC_W), .SEG_W(SEG_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/relbr_unit_test.sv
module relbr_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        flagC = 1'b0, flagS = 1'b0, flagZ = 1'b0, flagN = 1'b0;
  logic [15:0] curPc = '0;
  logic [5:0]  curSeg = '0;
  logic        outValid, isJump, taken;
  logic [15:0] nextPc;
  logic [5:0]  nextSeg;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Expected results, one entry per driven cycle.
  bit    qValid[$];
  bit    qJump[$];
  bit    qTaken[$];
  int    qLin[$];
  string qTag[$];

  always #2 clk = ~clk;  // 250 MHz

  relbr_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .flagC(flagC), .flagS(flagS), .flagZ(flagZ), .flagN(flagN),
    .curPc(curPc), .curSeg(curSeg), .outValid(outValid), .isJump(isJump),
    .taken(taken), .nextPc(nextPc), .nextSeg(nextSeg)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit condModel(input int code, input bit c, input bit s,
                                   input bit z, input bit n);
    if (code == 0)  return !c;
    if (code == 1)  return c;
    if (code == 2)  return !s;
    if (code == 3)  return s;
    if (code == 4)  return !z;
    if (code == 5)  return z;
    if (code == 6)  return !n;
    if (code == 7)  return n;
    if (code == 8)  return z || !c;
    if (code == 9)  return !z && c;
    if (code == 10) return z || s;
    if (code == 11) return !z && !s;
    if (code == 12) return n == s;
    if (code == 13) return n != s;
    return code == 14;
  endfunction

  // Compare outputs against the entry queued for the previous cycle.
  task automatic compareNow();
    bit v, j, t;
    int lin;
    string tag;
    if (qValid.size() == 0) return;
    v = qValid.pop_front(); j = qJump.pop_front(); t = qTaken.pop_front();
    lin = qLin.pop_front(); tag = qTag.pop_front();
    check(outValid == v, "R10", "outValid", outValid, v);
    if (v) begin
      check(isJump == j, tag, "isJump", isJump, j);
      check(taken == t, tag, "taken", taken, t);
      check({nextSeg, nextPc} == 22'(lin), tag, "next address",
            int'({nextSeg, nextPc}), lin);
    end
  endtask

  task automatic step(input bit v, input logic [15:0] w, input bit c, input bit s,
                      input bit z, input bit n, input logic [15:0] pc,
                      input logic [5:0] seg, input string tag);
    int code, opA, dir, disp, base, lin;
    bit j, t;
    @(negedge clk);
    compareNow();
    inValid = v; instrWord = w; flagC = c; flagS = s; flagZ = z; flagN = n;
    curPc = pc; curSeg = seg;
    code = int'(w[15:12]); opA = int'(w[11:9]); dir = int'(w[8:6]); disp = int'(w[5:0]);
    j = (opA == 0) && (code != 15);
    t = j && (dir <= 1) && condModel(code, c, s, z, n);
    base = (int'(seg) * 65536 + int'(pc) + 1) % 4194304;
    if (t && dir == 0)      lin = (base + disp) % 4194304;
    else if (t && dir == 1) lin = (base - disp + 4194304) % 4194304;
    else                    lin = base;
    qValid.push_back(v); qJump.push_back(j); qTaken.push_back(t);
    qLin.push_back(lin); qTag.push_back(tag);
  endtask

  function automatic logic [15:0] mkJump(input int code, input int dir, input int disp);
    return {4'(code), 3'd0, 3'(dir), 6'(disp)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!outValid && !isJump && !taken, "R1", "flags in reset",
          int'({outValid, isJump, taken}), 0);
    check(nextPc == 0 && nextSeg == 0, "R1", "address in reset",
          int'({nextSeg, nextPc}), 0);
    rstN = 1'b1;

    // R3: every condition code against every flag combination
    for (int code = 0; code < 15; code++)
      for (int f = 0; f < 16; f++)
        step(1, mkJump(code, f % 2, 3 + f), f[0], f[1], f[2], f[3], 16'h1000, 6'd5, "R3");

    // R4 / R5: forward and backward, distance 0 and 63
    step(1, mkJump(14, 0, 63), 0, 0, 0, 0, 16'h2000, 6'd7, "R4");
    step(1, mkJump(14, 0, 0),  0, 0, 0, 0, 16'h2000, 6'd7, "R4");
    step(1, mkJump(14, 1, 63), 0, 0, 0, 0, 16'h2000, 6'd7, "R5");
    step(1, mkJump(14, 1, 1),  0, 0, 0, 0, 16'h2000, 6'd7, "R5");

    // R2 / R6: non-jump words and the reserved 0xF nibble
    step(1, 16'hE23F, 0, 0, 0, 0, 16'h0100, 6'd1, "R2");
    step(1, 16'hF03F, 0, 0, 0, 0, 16'h0100, 6'd1, "R2");
    step(1, mkJump(5, 0, 10), 0, 0, 0, 0, 16'h0300, 6'd2, "R6");

    // R7: illegal direction values
    for (int d = 2; d < 8; d++)
      step(1, mkJump(14, d, 9), 1, 1, 1, 1, 16'h4000, 6'd3, "R7");

    // R8: forward segment carry, including rollover of segment 63
    step(1, mkJump(1, 0, 4),   0, 0, 0, 0, 16'hFFFF, 6'd3,  "R8");
    step(1, mkJump(14, 0, 63), 0, 0, 0, 0, 16'hFFF0, 6'd9,  "R8");
    step(1, 16'h1200,          0, 0, 0, 0, 16'hFFFF, 6'd63, "R8");

    // R9: backward segment borrow, including rollover of segment 0
    step(1, mkJump(14, 1, 5),  0, 0, 0, 0, 16'h0000, 6'd2, "R9");
    step(1, mkJump(14, 1, 63), 0, 0, 0, 0, 16'h0010, 6'd0, "R9");

    // R10: bubbles between valid words
    step(0, 16'h0000, 0, 0, 0, 0, 16'h0000, 6'd0, "R10");
    step(1, mkJump(14, 0, 2), 0, 0, 0, 0, 16'h0050, 6'd4, "R10");
    step(0, 16'h0000, 0, 0, 0, 0, 16'h0000, 6'd0, "R10");
    step(0, 16'h0000, 0, 0, 0, 0, 16'h0000, 6'd0, "R10");

    // Mixed random traffic across all requirements
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (i % 2 == 0) w[11:9] = 3'd0;
      if (i % 4 == 0) w[8:7] = 2'b00;
      step(($urandom % 5) != 0, w, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 16'($urandom), 6'($urandom), "R3/R4/R5/R6");
    end
    step(0, 16'h0000, 0, 0, 0, 0, 16'h0000, 6'd0, "R10");
    @(negedge clk);
    compareNow();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule